// File: doc/BRIEF.md
# IN Endpoint Transmit Handshake

This block holds the transmit side of one device IN endpoint built around a single packet buffer. Firmware fills the buffer a byte at a time through a write port while it owns the buffer, then raises a ready bit to hand the buffer to the bus side. When the packet layer reports an IN token, the block either streams the stored bytes to the serializer, with a valid/ready handshake and an end-of-packet strobe, or, if no packet is ready, asks for a NAK.

A host ACK returns the buffer to firmware. In the same clock edge, hardware clears the ready bit, empties the byte count, flips the DATA0/DATA1 toggle and sets a completion flag. The completion flag drives the endpoint interrupt. If a timeout strobe arrives instead of an ACK, the packet stays ready and is sent again, unchanged, on the next token. Firmware may load and arm the next packet before it clears the completion flag.

Top module: `in_ep_tx`

## Requirements
- R1: After reset pkt_rdy, tx_done, irq, tx_tog, fill_cnt, tx_valid, tx_eop and tx_nak are all 0.
- R2: A fw_wr_en pulse while pkt_rdy is 0 stores fw_wr_data and increments fill_cnt by one. While pkt_rdy is 1 a write is ignored: fill_cnt and the stored bytes are unchanged.
- R3: An IN token (tok_in) while pkt_rdy is 0 produces a one-cycle tx_nak in the cycle after the token, and no data is offered.
- R4: An IN token while pkt_rdy is 1 makes tx_valid high from the next cycle, presenting the stored bytes in write order on tx_data. Each byte advances on a cycle with tx_ready high. In the cycle after the last byte is taken, tx_eop is high for one cycle with tx_valid low.
- R5: A packet of zero bytes is legal: its token is followed directly by a tx_eop cycle with no tx_valid cycle.
- R6: An ack_rx pulse after tx_eop sets tx_done and clears pkt_rdy and fill_cnt at the same edge. An ack_rx at any other time has no effect.
- R7: irq equals tx_done at all times.
- R8: A tmo pulse after tx_eop leaves pkt_rdy set, tx_done and tx_tog unchanged. The next token resends the same bytes.
- R9: tx_tog (0 = DATA0, 1 = DATA1) inverts on every accepted ACK. A fw_tog_rst pulse forces it to 0 and wins over a simultaneous ACK.
- R10: tx_done is cleared only by fw_clr_done. When ack_rx and fw_clr_done fall in the same cycle, tx_done ends up 1. Writes and fw_set_rdy are accepted while tx_done is 1.
- R11: fill_cnt never exceeds DEPTH. A write made when fill_cnt equals DEPTH is dropped.
- R12: An IN token that arrives while a packet is being sent or is waiting for a handshake is ignored: it gives no tx_nak and does not restart the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | 8 | Firmware byte to store |
| fw_set_rdy | input | 1 | Firmware arms the packet |
| fw_clr_done | input | 1 | Firmware clears the completion flag |
| fw_tog_rst | input | 1 | Firmware resets the data toggle to DATA0 |
| tok_in | input | 1 | IN token addressed to this endpoint |
| ack_rx | input | 1 | Host ACK received |
| tmo | input | 1 | Handshake timeout strobe |
| tx_ready | input | 1 | Serializer accepts the current byte |
| tx_valid | output | 1 | A payload byte is offered |
| tx_data | output | 8 | Payload byte |
| tx_eop | output | 1 | End of the data packet |
| tx_nak | output | 1 | Answer the token with NAK |
| tx_tog | output | 1 | Data PID toggle (0 = DATA0) |
| pkt_rdy | output | 1 | Packet armed, buffer owned by the bus |
| tx_done | output | 1 | Transmit completed flag |
| irq | output | 1 | Endpoint interrupt |
| fill_cnt | output | $clog2(DEPTH+1) | Bytes held in the buffer |

## Verification
The completion flag is driven from two sides: the host ACK sets it and the firmware clear resets it, and both can land on the same edge. The bench provokes this by raising ack_rx and fw_clr_done together while the endpoint waits for its handshake. It expects tx_done and irq to stay 1 afterwards and to fall only after a later lone clear. A second collision, fw_tog_rst together with an ACK, is judged by tx_tog reading DATA0 while completion is still reported.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WACK = 2'd2
    } ep_state_e;
endpackage

// File: rtl/in_ep_buf.sv
module in_ep_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/in_ep_ctl.sv
module in_ep_ctl
    import in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_wr_en,
    input  logic          fw_set_rdy,
    input  logic          fw_clr_done,
    input  logic          fw_tog_rst,
    input  logic          tok_in,
    input  logic          ack_rx,
    input  logic          tmo,
    input  logic          tx_ready,
    output logic          buf_we,
    output logic [AW-1:0] buf_waddr,
    output logic [AW-1:0] buf_raddr,
    output logic          tx_valid,
    output logic          tx_eop,
    output logic          tx_nak,
    output logic          tx_tog,
    output logic          pkt_rdy,
    output logic          tx_done,
    output logic [CW-1:0] fill_cnt
);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        ep_state_e     st;
        logic          rdy;
        logic          done;
        logic          tog;
        logic          nak;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rptr;
    } ctl_t;

    ctl_t q, d;
    logic wr_ok;
    logic at_end;

    assign wr_ok  = fw_wr_en && !q.rdy && (q.cnt < CNT_MAX);
    assign at_end = (q.rptr == q.cnt);

    always_comb begin
        d     = q;
        d.nak = 1'b0;

        // firmware side: fill and arm only while it owns the buffer
        if (wr_ok) begin
            d.cnt = q.cnt + CNT_ONE;
        end
        if (fw_set_rdy && !q.rdy) begin
            d.rdy = 1'b1;
        end
        if (fw_clr_done) begin
            d.done = 1'b0;
        end

        // bus side
        unique case (q.st)
            ST_IDLE: begin
                if (tok_in) begin
                    if (q.rdy) begin
                        d.st   = ST_SEND;
                        d.rptr = '0;
                    end else begin
                        d.nak = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (at_end) begin
                    d.st = ST_WACK;
                end else if (tx_ready) begin
                    d.rptr = q.rptr + CNT_ONE;
                end
            end
            ST_WACK: begin
                if (ack_rx) begin
                    d.st   = ST_IDLE;
                    d.rdy  = 1'b0;
                    d.cnt  = '0;
                    d.done = 1'b1;
                    d.tog  = ~q.tog;
                end else if (tmo) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fw_tog_rst) begin
            d.tog = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rdy: 1'b0, done: 1'b0, tog: 1'b0,
                   nak: 1'b0, cnt: '0, rptr: '0};
        end else begin
            q <= d;
        end
    end

    assign buf_we    = wr_ok;
    assign buf_waddr = q.cnt[AW-1:0];
    assign buf_raddr = q.rptr[AW-1:0];
    assign tx_valid  = (q.st == ST_SEND) && !at_end;
    assign tx_eop    = (q.st == ST_SEND) && at_end;
    assign tx_nak    = q.nak;
    assign tx_tog    = q.tog;
    assign pkt_rdy   = q.rdy;
    assign tx_done   = q.done;
    assign fill_cnt  = q.cnt;
endmodule

// File: rtl/in_ep_tx.sv
module in_ep_tx #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_wr_en,
    input  logic [7:0]    fw_wr_data,
    input  logic          fw_set_rdy,
    input  logic          fw_clr_done,
    input  logic          fw_tog_rst,
    input  logic          tok_in,
    input  logic          ack_rx,
    input  logic          tmo,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_eop,
    output logic          tx_nak,
    output logic          tx_tog,
    output logic          pkt_rdy,
    output logic          tx_done,
    output logic          irq,
    output logic [CW-1:0] fill_cnt
);
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [AW-1:0] buf_raddr;

    in_ep_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fw_wr_en   (fw_wr_en),
        .fw_set_rdy (fw_set_rdy),
        .fw_clr_done(fw_clr_done),
        .fw_tog_rst (fw_tog_rst),
        .tok_in     (tok_in),
        .ack_rx     (ack_rx),
        .tmo        (tmo),
        .tx_ready   (tx_ready),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .buf_raddr  (buf_raddr),
        .tx_valid   (tx_valid),
        .tx_eop     (tx_eop),
        .tx_nak     (tx_nak),
        .tx_tog     (tx_tog),
        .pkt_rdy    (pkt_rdy),
        .tx_done    (tx_done),
        .fill_cnt   (fill_cnt)
    );

    in_ep_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(buf_waddr),
        .wdata(fw_wr_data),
        .raddr(buf_raddr),
        .rdata(tx_data)
    );

    assign irq = tx_done;
endmodule

// File: rtl/in_ep_tx_chk.sv
module in_ep_tx_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tok_in,
    input logic          fw_tog_rst,
    input logic          tx_valid,
    input logic          tx_eop,
    input logic          tx_nak,
    input logic          tx_tog,
    input logic          pkt_rdy,
    input logic          tx_done,
    input logic          irq,
    input logic [CW-1:0] fill_cnt
);
    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == tx_done);

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $fell(pkt_rdy));

    // R3
    nak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nak |-> $past(tok_in));

    // R2
    locked_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_rdy && $past(pkt_rdy)) |-> $stable(fill_cnt));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    // R4
    eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_eop));

    // R9
    tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fw_tog_rst) |-> !tx_tog);
endmodule

bind in_ep_tx in_ep_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok_in),
    .fw_tog_rst(fw_tog_rst),
    .tx_valid  (tx_valid),
    .tx_eop    (tx_eop),
    .tx_nak    (tx_nak),
    .tx_tog    (tx_tog),
    .pkt_rdy   (pkt_rdy),
    .tx_done   (tx_done),
    .irq       (irq),
    .fill_cnt  (fill_cnt)
);

// File: tb/sim_in_ep_tx.sv
`timescale 1ns/1ps
module sim_in_ep_tx;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fw_wr_en = 1'b0;
    logic [7:0]    fw_wr_data = '0;
    logic          fw_set_rdy = 1'b0;
    logic          fw_clr_done = 1'b0;
    logic          fw_tog_rst = 1'b0;
    logic          tok_in = 1'b0;
    logic          ack_rx = 1'b0;
    logic          tmo = 1'b0;
    logic          tx_ready = 1'b1;
    logic          tx_valid, tx_eop, tx_nak, tx_tog, pkt_rdy, tx_done, irq;
    logic [7:0]    tx_data;
    logic [CW-1:0] fill_cnt;

    int total = 0;
    int bad = 0;
    logic exp_tog = 1'b0;
    logic [7:0] pkt [DEPTH];

    always #2 clk = ~clk;

    in_ep_tx #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
        .fw_set_rdy(fw_set_rdy), .fw_clr_done(fw_clr_done), .fw_tog_rst(fw_tog_rst),
        .tok_in(tok_in), .ack_rx(ack_rx), .tmo(tmo), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_eop(tx_eop), .tx_nak(tx_nak),
        .tx_tog(tx_tog), .pkt_rdy(pkt_rdy), .tx_done(tx_done), .irq(irq),
        .fill_cnt(fill_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] b);
        fw_wr_en = 1'b1; fw_wr_data = b;
        step();
        fw_wr_en = 1'b0;
    endtask

    task automatic arm();
        fw_set_rdy = 1'b1;
        step();
        fw_set_rdy = 1'b0;
    endtask

    task automatic load(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            pkt[i] = 8'(base + i);
            wr(pkt[i]);
        end
        chk(fill_cnt == CW'(n), "R2 fill count", int'(fill_cnt), n);
        arm();
        chk(pkt_rdy == 1'b1, "R4 armed", int'(pkt_rdy), 1);
    endtask

    // token, then stream n bytes expecting pkt[]; ends in the handshake wait
    task automatic stream(input int n, input string req);
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        chk(tx_nak == 1'b0, {req, " no nak"}, int'(tx_nak), 0);
        for (int i = 0; i < n; i++) begin
            chk(tx_valid && tx_data == pkt[i], {req, " byte"}, int'(tx_data), int'(pkt[i]));
            step();
        end
        chk(tx_eop && !tx_valid, {req, " eop"}, int'(tx_eop), 1);
        chk(tx_tog == exp_tog, {req, " toggle"}, int'(tx_tog), int'(exp_tog));
        step();
        chk(!tx_eop && !tx_valid, {req, " eop one cycle"}, int'(tx_eop), 0);
    endtask

    task automatic ack();
        ack_rx = 1'b1;
        step();
        ack_rx = 1'b0;
        exp_tog = ~exp_tog;
        chk(tx_done && irq, "R6 done on ack", int'(tx_done), 1);
        chk(!pkt_rdy && fill_cnt == 0, "R6 buffer released", int'(fill_cnt), 0);
        chk(tx_tog == exp_tog, "R9 toggle flips", int'(tx_tog), int'(exp_tog));
    endtask

    task automatic clr_done();
        fw_clr_done = 1'b1;
        step();
        fw_clr_done = 1'b0;
        chk(!tx_done && !irq, "R10 done cleared", int'(tx_done), 0);
    endtask

    task automatic t_reset();
        chk(!pkt_rdy && !tx_done && !irq && !tx_tog, "R1 flags", int'(pkt_rdy), 0);
        chk(fill_cnt == 0 && !tx_valid && !tx_eop && !tx_nak, "R1 datapath", int'(fill_cnt), 0);
    endtask

    task automatic t_nak();
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        chk(tx_nak && !tx_valid, "R3 nak", int'(tx_nak), 1);
        step();
        chk(!tx_nak, "R3 nak one cycle", int'(tx_nak), 0);
    endtask

    task automatic t_basic();
        load(3, 8'h10);
        stream(3, "R4");
        ack();
        clr_done();
    endtask

    task automatic t_zero();
        load(0, 0);
        stream(0, "R5");
        ack();
        clr_done();
    endtask

    task automatic t_stall();
        load(2, 8'hA0);
        tx_ready = 1'b0;
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        step();
        step();
        chk(tx_valid && tx_data == pkt[0], "R4 stall holds", int'(tx_data), int'(pkt[0]));
        tx_ready = 1'b1;
        step();
        chk(tx_valid && tx_data == pkt[1], "R4 after stall", int'(tx_data), int'(pkt[1]));
        step();
        chk(tx_eop, "R4 eop after stall", int'(tx_eop), 1);
        step();
        ack();
        clr_done();
    endtask

    task automatic t_timeout();
        load(2, 8'h55);
        stream(2, "R8 first");
        tmo = 1'b1;
        step();
        tmo = 1'b0;
        chk(pkt_rdy && !tx_done, "R8 stays armed", int'(pkt_rdy), 1);
        chk(tx_tog == exp_tog, "R8 toggle kept", int'(tx_tog), int'(exp_tog));
        stream(2, "R8 resend");
        ack();
        clr_done();
    endtask

    task automatic t_locked();
        load(2, 8'h30);
        wr(8'hEE);
        chk(fill_cnt == 2, "R2 write ignored", int'(fill_cnt), 2);
        stream(2, "R2 data intact");
        ack();
        clr_done();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            pkt[i] = 8'(i * 3 + 1);
            wr(pkt[i]);
        end
        wr(8'hFF);
        chk(fill_cnt == CW'(DEPTH), "R11 capped", int'(fill_cnt), DEPTH);
        arm();
        stream(DEPTH, "R11 full packet");
        ack();
        clr_done();
    endtask

    task automatic t_ignore();
        ack_rx = 1'b1;
        step();
        ack_rx = 1'b0;
        chk(!tx_done && tx_tog == exp_tog, "R6 stray ack ignored", int'(tx_done), 0);
        load(1, 8'h77);
        stream(1, "R12 setup");
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        step();
        chk(!tx_nak && !tx_valid && !tx_eop, "R12 token ignored", int'(tx_nak), 0);
        ack();
        clr_done();
    endtask

    task automatic t_collide();
        load(1, 8'h42);
        stream(1, "R10 first");
        ack();
        // stage next packet while done is still set
        load(2, 8'h90);
        chk(tx_done, "R10 done held while staging", int'(tx_done), 1);
        stream(2, "R10 second");
        ack_rx = 1'b1; fw_clr_done = 1'b1;
        step();
        ack_rx = 1'b0; fw_clr_done = 1'b0;
        exp_tog = ~exp_tog;
        chk(tx_done && irq, "R10 set beats clear", int'(tx_done), 1);
        chk(!pkt_rdy, "R10 released", int'(pkt_rdy), 0);
        clr_done();
    endtask

    task automatic t_tog();
        fw_tog_rst = 1'b1;
        step();
        fw_tog_rst = 1'b0;
        exp_tog = 1'b0;
        chk(!tx_tog, "R9 toggle reset", int'(tx_tog), 0);
        load(1, 8'h01);
        stream(1, "R9 data0");
        ack();
        load(1, 8'h02);
        stream(1, "R9 data1");
        ack_rx = 1'b1; fw_tog_rst = 1'b1;
        step();
        ack_rx = 1'b0; fw_tog_rst = 1'b0;
        exp_tog = 1'b0;
        chk(!tx_tog && tx_done, "R9 reset beats ack", int'(tx_tog), 0);
        clr_done();
    endtask

    initial begin
        #20000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_nak();
        t_basic();
        t_zero();
        t_stall();
        t_timeout();
        t_locked();
        t_overflow();
        t_ignore();
        t_collide();
        t_tog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule